// File: doc/BRIEF.md
# Interrupt Output Aggregator

This block gathers interrupt events from a monitoring device and drives two active-low, registered output pins: a general interrupt line and a thermal-alarm line. Limit comparators elsewhere deliver error events as single-cycle pulses: general sources, thermal error sources and a set of external active-high IRQ inputs. Each event sets a sticky status bit. The status bits sit in two read-to-clear banks that software reads through the configuration block.

The pins are kept separate from the status. The enable and clear controls act only on the pin drivers, so forcing a pin inactive never loses a latched event. Per-bit masks take a status bit out of the interrupt decision while the bit still records its event. A routing control decides whether thermal errors also reach the general interrupt line. Each external IRQ input has its own enable. A mode flag picks whether the thermal pin shows latched thermal status or the live thermal events.

Top module: `irq_aggregator`

## Requirements
- R1: During and after reset, with no events, every bit of `status_o` is 0 and both `int_n_o` and `thm_n_o` are 1.
- R2: An event sets its status bit at the next clock edge, and the bit stays set until its bank is read. The status vector has general sources in bits [N_SRC-1:0], thermal sources in the next N_THM bits and external IRQs in the top N_EXT bits. `stat_rd_i[0]` clears the general bank and `stat_rd_i[1]` clears the thermal and external bank. A read does not touch the other bank. An event that arrives in the same cycle as a read of its bank leaves its bit set.
- R3: A status bit whose `mask_i` bit (same position as the status bit) is 1 still latches, but it does not pull `int_n_o` low.
- R4: `int_n_o` goes to 0 one cycle after the status holds an unmasked, routed bit, provided `int_en_i`=1 and `int_clr_i`=0. Otherwise it is 1. With `int_en_i`=0 it stays 1.
- R5: While `int_clr_i`=1, `int_n_o` is 1 and the status bits are kept. When `int_clr_i` returns to 0, `int_n_o` asserts again from the status it kept.
- R6: With `thm_route_off_i`=0, thermal status bits take part in `int_n_o`. With `thm_route_off_i`=1 they are left out.
- R7: An external IRQ input whose `ext_en_i` bit is 0 is ignored: its status bit does not latch and it does not affect `int_n_o`.
- R8: With `thm_acpi_i`=0, `thm_n_o` is 0 one cycle after any thermal status bit is set, provided `thm_en_i`=1 and `thm_clr_i`=0. `thm_n_o` does not depend on `mask_i`. While `thm_en_i`=0 or `thm_clr_i`=1 it is 1, and the status bits are kept.
- R9: With `thm_acpi_i`=1, `thm_n_o` follows the live thermal event inputs one cycle later and ignores the latched thermal status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | N_SRC | General error event pulses |
| thm_evt_i | input | N_THM | Thermal error events |
| ext_irq_i | input | N_EXT | External active-high IRQ inputs |
| ext_en_i | input | N_EXT | Per-input enable for the external IRQs |
| mask_i | input | N_SRC+N_THM+N_EXT | Per-status-bit interrupt mask, 1 = masked |
| stat_rd_i | input | 2 | Bank read strobes (clear on read) |
| int_en_i | input | 1 | Interrupt pin enable |
| int_clr_i | input | 1 | Hold interrupt pin inactive |
| thm_route_off_i | input | 1 | 1 = thermal events left out of the interrupt pin |
| thm_en_i | input | 1 | Thermal pin enable |
| thm_clr_i | input | 1 | Hold thermal pin inactive |
| thm_acpi_i | input | 1 | Thermal pin mode, 1 = follow live events |
| int_n_o | output | 1 | Interrupt pin, active low |
| thm_n_o | output | 1 | Thermal pin, active low |
| status_o | output | N_SRC+N_THM+N_EXT | Latched status bits |

## Verification
A status bit stuck at 0 shows up one edge after its event as a missing `status_o` bit, and the pins stay high one edge later. A status bit stuck at 1 survives a bank read and appears on `status_o` in the cycle after that read. A wrong routing, mask or enable decision shows up only at a pin, two edges after the event. For that reason the vectors pair each event pattern with one setting of the controls, and the expected pin levels are computed from those controls alone. A pin-hold control that wrongly clears status is caught when the pin reasserts after the hold is released.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int MAXW = 32;
  localparam int BANK_GEN = 0;
  localparam int BANK_AUX = 1;

  // Interrupt decision: a bit counts when it is latched, unmasked and routed.
  function automatic logic int_request(logic [MAXW-1:0] st,
                                       logic [MAXW-1:0] mk,
                                       logic [MAXW-1:0] route);
    return |(st & ~mk & route);
  endfunction

  // Next value of a sticky bank: a set has priority over the read-clear.
  function automatic logic [MAXW-1:0] sticky_next(logic [MAXW-1:0] q,
                                                  logic [MAXW-1:0] set,
                                                  logic rd);
    return (rd ? '0 : q) | set;
  endfunction
endpackage

// File: rtl/ia_status_bank.sv
module ia_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] q_o
);
  logic [ia_pkg::MAXW-1:0] nxt;

  assign nxt = ia_pkg::sticky_next(ia_pkg::MAXW'(q_o), ia_pkg::MAXW'(set_i), rd_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt[W-1:0];
  end
endmodule

// File: rtl/ia_pin_drv.sv
module ia_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hold_i,
  input  logic req_i,
  output logic pin_n_o
);
  logic drive;

  assign drive = en_i & ~hold_i & req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_n_o <= 1'b1;
    else        pin_n_o <= ~drive;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC = 8,
  parameter int N_THM = 2,
  parameter int N_EXT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             evt_i,
  input  logic [N_THM-1:0]             thm_evt_i,
  input  logic [N_EXT-1:0]             ext_irq_i,
  input  logic [N_EXT-1:0]             ext_en_i,
  input  logic [N_SRC+N_THM+N_EXT-1:0] mask_i,
  input  logic [1:0]                   stat_rd_i,
  input  logic                         int_en_i,
  input  logic                         int_clr_i,
  input  logic                         thm_route_off_i,
  input  logic                         thm_en_i,
  input  logic                         thm_clr_i,
  input  logic                         thm_acpi_i,
  output logic                         int_n_o,
  output logic                         thm_n_o,
  output logic [N_SRC+N_THM+N_EXT-1:0] status_o
);
  localparam int ST_W  = N_SRC + N_THM + N_EXT;
  localparam int AUX_W = N_THM + N_EXT;
  localparam logic [ST_W-1:0] THM_FIELD = ST_W'(((64'd1 << N_THM) - 64'd1) << N_SRC);

  // Named internal events, brought out for observation
  logic [N_SRC-1:0]  gen_set;
  logic [AUX_W-1:0]  aux_set;
  logic [N_SRC-1:0]  gen_q;
  logic [AUX_W-1:0]  aux_q;
  logic [ST_W-1:0]   route;
  logic              int_req;
  logic              thm_req;

  assign gen_set = evt_i;
  assign aux_set = {ext_irq_i & ext_en_i, thm_evt_i};

  ia_status_bank #(.W(N_SRC)) u_gen_bank (
    .clk(clk), .rst_n(rst_n), .set_i(gen_set),
    .rd_i(stat_rd_i[ia_pkg::BANK_GEN]), .q_o(gen_q)
  );

  ia_status_bank #(.W(AUX_W)) u_aux_bank (
    .clk(clk), .rst_n(rst_n), .set_i(aux_set),
    .rd_i(stat_rd_i[ia_pkg::BANK_AUX]), .q_o(aux_q)
  );

  assign status_o = {aux_q, gen_q};
  assign route    = thm_route_off_i ? ~THM_FIELD : '1;

  assign int_req = ia_pkg::int_request(ia_pkg::MAXW'(status_o),
                                       ia_pkg::MAXW'(mask_i),
                                       ia_pkg::MAXW'(route));
  assign thm_req = thm_acpi_i ? |thm_evt_i : |aux_q[N_THM-1:0];

  ia_pin_drv u_int_drv (
    .clk(clk), .rst_n(rst_n), .en_i(int_en_i), .hold_i(int_clr_i),
    .req_i(int_req), .pin_n_o(int_n_o)
  );

  ia_pin_drv u_thm_drv (
    .clk(clk), .rst_n(rst_n), .en_i(thm_en_i), .hold_i(thm_clr_i),
    .req_i(thm_req), .pin_n_o(thm_n_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_SRC = 8,
  parameter int N_THM = 2,
  parameter int N_EXT = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_SRC-1:0]             evt_i,
  input logic [N_EXT-1:0]             ext_en_i,
  input logic [1:0]                   stat_rd_i,
  input logic                         int_en_i,
  input logic                         int_clr_i,
  input logic                         thm_en_i,
  input logic                         thm_clr_i,
  input logic                         int_n_o,
  input logic                         thm_n_o,
  input logic [N_SRC+N_THM+N_EXT-1:0] status_o
);
  localparam int EXT0 = N_SRC + N_THM;

  AST_INT_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(int_en_i) || $past(int_clr_i)) |-> int_n_o); // R4

  AST_INT_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_clr_i) && !$past(stat_rd_i[0])) |->
      ((status_o[N_SRC-1:0] & $past(status_o[N_SRC-1:0])) == $past(status_o[N_SRC-1:0]))); // R5

  AST_THM_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(thm_en_i) || $past(thm_clr_i)) |-> thm_n_o); // R8

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_i[0]) |-> status_o[0]); // R2

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd_i[0]) && ($past(evt_i) == '0)) |-> (status_o[N_SRC-1:0] == '0)); // R2

  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ext_en_i[0]) && !$past(status_o[EXT0])) |-> !status_o[EXT0]); // R7
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC), .N_THM(N_THM), .N_EXT(N_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ext_en_i(ext_en_i), .stat_rd_i(stat_rd_i),
  .int_en_i(int_en_i), .int_clr_i(int_clr_i), .thm_en_i(thm_en_i), .thm_clr_i(thm_clr_i),
  .int_n_o(int_n_o), .thm_n_o(thm_n_o), .status_o(status_o)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic [1:0]  thm_evt_i, ext_irq_i, ext_en_i, stat_rd_i;
  logic [11:0] mask_i;
  logic        int_en_i, int_clr_i, thm_route_off_i, thm_en_i, thm_clr_i, thm_acpi_i;
  logic        int_n_o, thm_n_o;
  logic [11:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator #(.N_SRC(8), .N_THM(2), .N_EXT(2)) u0 (.*);

  typedef struct packed {
    logic [7:0]  ev;
    logic [1:0]  th;
    logic [1:0]  ex;
    logic [11:0] mk;
    logic        ie, te, xl;
    logic [1:0]  ien;
    logic        e_int, e_thm;
    logic [11:0] e_st;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{8'h01, 2'b00, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 12'h001}, // R4 general
    '{8'h01, 2'b00, 2'b00, 12'h001, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 12'h001}, // R3 masked
    '{8'h00, 2'b01, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 12'h100}, // R6 routed
    '{8'h00, 2'b01, 2'b00, 12'h000, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 12'h100}, // R6 excluded
    '{8'h00, 2'b00, 2'b01, 12'h000, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 12'h000}, // R7 ignored
    '{8'h00, 2'b00, 2'b01, 12'h000, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 12'h400}, // R7 enabled
    '{8'h80, 2'b00, 2'b00, 12'h000, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 12'h080}, // R4 disabled
    '{8'h00, 2'b10, 2'b00, 12'h200, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 12'h200}, // R8 off, R3
    '{8'h00, 2'b10, 2'b10, 12'h000, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 12'hA00}  // R6 R7 mix
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; thm_evt_i = '0; ext_irq_i = '0; ext_en_i = '0;
    stat_rd_i = '0; mask_i = '0; int_en_i = 1'b0; int_clr_i = 1'b0;
    thm_route_off_i = 1'b0; thm_en_i = 1'b0; thm_clr_i = 1'b0; thm_acpi_i = 1'b0;
    tick(); tick();
    check("R1 status", 32'(status_o), 32'h0);
    check("R1 int_n", 32'(int_n_o), 32'h1);
    check("R1 thm_n", 32'(thm_n_o), 32'h1);
    rst_n = 1'b1;
    tick();
    check("R1 status after release", 32'(status_o), 32'h0);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      mask_i = VECS[i].mk; int_en_i = VECS[i].ie; thm_en_i = VECS[i].te;
      thm_route_off_i = VECS[i].xl; ext_en_i = VECS[i].ien;
      stat_rd_i = 2'b11;
      tick();
      stat_rd_i = 2'b00;
      evt_i = VECS[i].ev; thm_evt_i = VECS[i].th; ext_irq_i = VECS[i].ex;
      tick();
      evt_i = '0; thm_evt_i = '0; ext_irq_i = '0;
      tick();
      check($sformatf("R2 vec%0d status", i), 32'(status_o), 32'(VECS[i].e_st));
      check($sformatf("R4 vec%0d int_n", i), 32'(int_n_o), 32'(VECS[i].e_int));
      check($sformatf("R8 vec%0d thm_n", i), 32'(thm_n_o), 32'(VECS[i].e_thm));
    end

    // R5: interrupt hold keeps status and resumes
    mask_i = '0; int_en_i = 1'b1; thm_en_i = 1'b1; thm_route_off_i = 1'b0; ext_en_i = '0;
    stat_rd_i = 2'b11; tick(); stat_rd_i = 2'b00;
    evt_i = 8'h01; tick(); evt_i = '0; tick();
    check("R5 int before hold", 32'(int_n_o), 32'h0);
    int_clr_i = 1'b1; tick();
    check("R5 int held", 32'(int_n_o), 32'h1);
    tick(); tick();
    check("R5 int still held", 32'(int_n_o), 32'h1);
    check("R5 status kept", 32'(status_o), 32'h001);
    int_clr_i = 1'b0; tick();
    check("R5 int resumes", 32'(int_n_o), 32'h0);

    // R2: bank independence, read-clear, set beats read
    stat_rd_i = 2'b10; tick(); stat_rd_i = 2'b00;
    check("R2 other bank read keeps bit", 32'(status_o), 32'h001);
    stat_rd_i = 2'b01; evt_i = 8'h02; tick(); stat_rd_i = 2'b00; evt_i = '0;
    check("R2 set wins over read", 32'(status_o), 32'h002);
    tick(); tick();
    check("R2 bit held", 32'(status_o), 32'h002);
    stat_rd_i = 2'b01; tick(); stat_rd_i = 2'b00;
    check("R2 read clears", 32'(status_o), 32'h000);
    tick();
    check("R4 int released", 32'(int_n_o), 32'h1);

    // R8: thermal pin in default mode, mask has no effect, hold keeps status
    mask_i = 12'h100;
    thm_evt_i = 2'b01; tick(); thm_evt_i = '0; tick();
    check("R8 thm asserted while masked", 32'(thm_n_o), 32'h0);
    check("R3 masked thermal keeps int high", 32'(int_n_o), 32'h1);
    thm_clr_i = 1'b1; tick();
    check("R8 thm held", 32'(thm_n_o), 32'h1);
    check("R8 status kept", 32'(status_o), 32'h100);
    thm_clr_i = 1'b0; tick();
    check("R8 thm resumes", 32'(thm_n_o), 32'h0);

    // R9: live-event mode ignores latched thermal status
    thm_acpi_i = 1'b1; tick();
    check("R9 latched status ignored", 32'(thm_n_o), 32'h1);
    thm_evt_i = 2'b10; tick();
    check("R9 follows live event", 32'(thm_n_o), 32'h0);
    tick();
    check("R9 still low while event held", 32'(thm_n_o), 32'h0);
    thm_evt_i = '0; tick();
    check("R9 releases with event", 32'(thm_n_o), 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule